// File: doc/BRIEF.md
# Stereo Serial Audio Sample Transmitter

This block takes one parallel stereo pair of 24-bit two's-complement samples and shifts it out, most significant bit first, on a single serial data line. The serial bit clock and the word-select (channel) clock are inputs; it does not matter whether they are produced on the same chip or come from another device. The block watches both with its own fast system clock and changes the data line only on bit-clock falling edges, so the receiver can take each bit on the following rising edge.

A static format input picks between two timings. In the delayed format the first data bit follows the word-select transition by one bit-clock period and the left channel goes out while word-select is low. In the justified format the first data bit starts right at the transition and the left channel goes out while word-select is high. Frames of 48 or 64 bit clocks need no setting: a slot counter restarts at every word-select transition, and the slots after the last data bit of a channel carry zeros.

A sample pair is handed over with a valid signal and is taken only at the start of a left half-frame. The block answers with a one-cycle accept strobe. If no pair is offered at that moment, the pair already held is sent again.

Top module: `sertx_top`

## Requirements
- R1: While reset is held and at the first cycle after it is released, `sdout` is 0 and `in_ready` is 0.
- R2: Each channel word is sent as 24 bits, bit 23 first and bit 0 last, with one bit per bit-clock period.
- R3: With `fmt_i2s` = 0, bit 23 occupies the bit-clock period that starts at the falling edge where `lrck` changes (slot 0). The left word is sent while `lrck` = 1 and the right word while `lrck` = 0.
- R4: With `fmt_i2s` = 1, bit 23 occupies slot 1 after the `lrck` change and bit 0 occupies slot 24. In a 24-slot half, slot 24 is slot 0 of the next half. The left word is sent while `lrck` = 0 and the right word while `lrck` = 1.
- R5: Every slot after bit 0 of a word, up to the next `lrck` change, carries 0.
- R6: `sdout` changes only in the system-clock cycle that follows a detected falling edge of `sclk`, so it is stable across every rising edge of `sclk`.
- R7: When `in_valid` = 1 at the falling edge that starts a left half, `in_left`/`in_right` are taken and sent from that half on, and `in_ready` is 1 for exactly that one system-clock cycle. `in_ready` is never 1 at any other time.
- R8: When `in_valid` = 0 at the start of a left half, the previously held pair is sent again and `in_ready` stays 0.
- R9: Frames of 48 and 64 bit clocks (24 or 32 slots per half) are both sent correctly with no configuration change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; much faster than `sclk` |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_i2s | input | 1 | Static format select: 1 = one-slot-delayed format, 0 = justified format |
| sclk | input | 1 | Serial bit clock, synchronous to `clk` |
| lrck | input | 1 | Word-select clock; changes on `sclk` falling edges |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| in_valid | input | 1 | A new sample pair is offered |
| in_ready | output | 1 | One-cycle strobe: offered pair taken |
| sdout | output | 1 | Serial data output |

## Verification
A wrong slot count or a missed word-select transition shows up on `sdout` within one half-frame: the data bits shift by one or more positions, or the padding zeros move into the data. A wrong channel polarity or a stale held pair shows in the first word after the error, because the monitor checks every bit at every `sclk` rising edge against a queue of expected bits. Handshake faults show as a wrong count of `in_ready` strobes against the number of left-half starts that had `in_valid` set.

// File: rtl/sertx_pkg.sv
// Shared definitions for the serial sample transmitter.
package sertx_pkg;
    // Format select encoding on the fmt_i2s input
    typedef enum logic {
        FMT_JUSTIFIED = 1'b0,
        FMT_DELAYED   = 1'b1
    } fmt_e;
endpackage

// File: rtl/sertx_edge.sv
// Bit-clock and word-select edge detector.
// Assumes sclk and lrck are synchronous to clk and that each phase of sclk
// lasts at least one clk cycle. It flags an sclk falling edge and, at that
// edge, whether lrck differs from its value at the previous falling edge.
module sertx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic lrck,
    output logic sclk_fall,
    output logic half_start
);
    logic sclk_q;
    logic lrck_seen;

    // Remember the previous bit-clock level and the word-select level seen at the last fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q    <= 1'b0;
            lrck_seen <= 1'b0;
        end else begin
            sclk_q <= sclk;
            if (sclk_fall) lrck_seen <= lrck;
        end
    end

    // Falling edge of the bit clock and a word-select change at that edge
    always_comb begin
        sclk_fall  = sclk_q & ~sclk;
        half_start = (lrck != lrck_seen);
    end
endmodule

// File: rtl/sertx_slot.sv
// Slot counter within one word-select half.
// Restarts at 0 on the falling edge where word-select changes, counts up on
// every other falling edge and saturates, so any half length up to the
// counter range is handled. Reset value is the saturated value, so the
// line stays at zero until the first word-select change.
module sertx_slot #(
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_fall,
    input  logic              half_start,
    output logic [SLOT_W-1:0] slot_next,
    output logic [SLOT_W-1:0] slot_q
);
    localparam logic [SLOT_W-1:0] SLOT_MAX = {SLOT_W{1'b1}};

    // Slot index for the bit-clock period that begins at this falling edge
    always_comb begin
        if (half_start)            slot_next = '0;
        else if (slot_q == SLOT_MAX) slot_next = SLOT_MAX;
        else                       slot_next = slot_q + 1'b1;
    end

    // Hold the current slot index between falling edges
    always_ff @(posedge clk) begin
        if (!rst_n)         slot_q <= SLOT_MAX;
        else if (sclk_fall) slot_q <= slot_next;
    end
endmodule

// File: rtl/sertx_shift.sv
// Sample holder and bit selector.
// Takes a new pair at the falling edge that opens a left half when one is
// offered, picks the bit of the active channel for the slot that starts,
// and keeps a one-slot-delayed copy of the bit stream for the delayed format.
module sertx_shift #(
    parameter int SAMPLE_W = 24,
    parameter int SLOT_W   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk_fall,
    input  logic                half_start,
    input  logic                is_left,
    input  logic [SLOT_W-1:0]   slot_next,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    input  logic                in_valid,
    output logic                in_ready,
    output logic                just_bit,
    output logic                late_bit
);
    localparam int IDX_W = $clog2(SAMPLE_W);

    logic                take;
    logic [SAMPLE_W-1:0] left_q, right_q;
    logic [SAMPLE_W-1:0] word;
    logic [IDX_W-1:0]    idx;
    logic                bit_now;

    // Accept a pair only when a left half opens with valid data offered
    assign take     = sclk_fall & half_start & is_left & in_valid;
    assign in_ready = take;

    // Select the word of the active channel and the bit for the starting slot
    always_comb begin
        if (is_left) word = take ? in_left  : left_q;
        else         word = take ? in_right : right_q;
        idx     = '0;
        bit_now = 1'b0;
        if (slot_next < SLOT_W'(SAMPLE_W)) begin
            idx     = IDX_W'(SAMPLE_W - 1) - slot_next[IDX_W-1:0];
            bit_now = word[idx];
        end
    end

    // Hold the pair and advance the justified and delayed bit streams
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q   <= '0;
            right_q  <= '0;
            just_bit <= 1'b0;
            late_bit <= 1'b0;
        end else begin
            if (take) begin
                left_q  <= in_left;
                right_q <= in_right;
            end
            if (sclk_fall) begin
                late_bit <= just_bit;
                just_bit <= bit_now;
            end
        end
    end
endmodule

// File: rtl/sertx_top.sv
// Stereo serial sample transmitter, top level.
// Assumes sclk/lrck are synchronous to clk, lrck changes on sclk falling
// edges, and fmt_i2s is held constant outside reset.
module sertx_top
    import sertx_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int SLOT_W   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fmt_i2s,
    input  logic                sclk,
    input  logic                lrck,
    input  logic [SAMPLE_W-1:0] in_left,
    input  logic [SAMPLE_W-1:0] in_right,
    input  logic                in_valid,
    output logic                in_ready,
    output logic                sdout
);
    logic              sclk_fall;
    logic              half_start;
    logic              is_left;
    logic [SLOT_W-1:0] slot_next;
    logic [SLOT_W-1:0] slot_q;
    logic              just_bit;
    logic              late_bit;
    fmt_e              fmt;

    assign fmt = fmt_e'(fmt_i2s);

    // Left channel polarity of word-select depends on the format
    assign is_left = (fmt == FMT_DELAYED) ? ~lrck : lrck;

    sertx_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk       (sclk),
        .lrck       (lrck),
        .sclk_fall  (sclk_fall),
        .half_start (half_start)
    );

    sertx_slot #(.SLOT_W(SLOT_W)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_fall  (sclk_fall),
        .half_start (half_start),
        .slot_next  (slot_next),
        .slot_q     (slot_q)
    );

    sertx_shift #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_fall  (sclk_fall),
        .half_start (half_start),
        .is_left    (is_left),
        .slot_next  (slot_next),
        .in_left    (in_left),
        .in_right   (in_right),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .just_bit   (just_bit),
        .late_bit   (late_bit)
    );

    // Delayed format uses the stream shifted by one slot
    assign sdout = (fmt == FMT_DELAYED) ? late_bit : just_bit;
endmodule

// File: rtl/sertx_chk.sv
// Property checker for sertx_top, attached with bind below.
module sertx_chk #(
    parameter int SAMPLE_W = 24,
    parameter int SLOT_W   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fmt_i2s,
    input logic              sdout,
    input logic              in_ready,
    input logic              in_valid,
    input logic              sclk_fall,
    input logic [SLOT_W-1:0] slot_q
);
    // R6: data line moves only right after a bit-clock falling edge
    p_sdout_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdout) |-> $past(sclk_fall));

    // R7: accept strobe only with valid data offered
    p_ready_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> in_valid);

    // R7: accept strobe only at a bit-clock falling edge
    p_ready_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> sclk_fall);

    // R5: justified format drives zero in slots after the last data bit
    p_pad_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fmt_i2s && slot_q >= SLOT_W'(SAMPLE_W)) |-> (sdout == 1'b0));
endmodule

bind sertx_top sertx_chk #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fmt_i2s   (fmt_i2s),
    .sdout     (sdout),
    .in_ready  (in_ready),
    .in_valid  (in_valid),
    .sclk_fall (sclk_fall),
    .slot_q    (slot_q)
);

// File: tb/tb_sertx_top.sv
module tb_sertx_top;
    localparam int SW = 24;

    typedef struct {
        logic  b;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fmt_i2s = 1'b0;
    logic          sclk = 1'b1;
    logic          lrck = 1'b0;
    logic [SW-1:0] in_left = '0;
    logic [SW-1:0] in_right = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic          sdout;

    int n_checks = 0;
    int n_fail   = 0;
    int acc_cnt  = 0;
    int exp_acc  = 0;

    exp_t q[$];

    // model state
    logic [SW-1:0] m_left, m_right;
    logic          m_prev;
    string         m_prev_tag;
    logic          drop_valid;

    always #4 clk = ~clk;

    sertx_top dut (
        .clk(clk), .rst_n(rst_n), .fmt_i2s(fmt_i2s), .sclk(sclk), .lrck(lrck),
        .in_left(in_left), .in_right(in_right), .in_valid(in_valid),
        .in_ready(in_ready), .sdout(sdout)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count accept strobes, sampled between clock edges
    always @(negedge clk) begin
        #2;
        if (!rst_n) acc_cnt = 0;
        else if (in_ready === 1'b1) acc_cnt++;
    end

    // Monitor: compare every bit at the receiver sampling edge
    always @(posedge sclk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(e.tag, sdout, e.b);
        end
    end

    task automatic do_reset(input logic fmt);
        @(negedge clk);
        rst_n = 1'b0; sclk = 1'b1; lrck = 1'b0; in_valid = 1'b0; fmt_i2s = fmt;
        repeat (4) @(negedge clk);
        check("R1", sdout, 1'b0);
        check("R1", in_ready, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        check("R1", sdout, 1'b0);
        check("R1", in_ready, 1'b0);
        m_left = '0; m_right = '0; m_prev = 1'b0; m_prev_tag = "R1";
        exp_acc = 0; drop_valid = 1'b0;
    endtask

    task automatic slot_step(input logic lv);
        @(negedge clk);
        sclk = 1'b0; lrck = lv;
        @(negedge clk);
        if (drop_valid) begin in_valid = 1'b0; drop_valid = 1'b0; end
        repeat (2) @(negedge clk);
        sclk = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // Driver: one word-select half, pushing the expected bit of each slot
    task automatic run_half(input logic lv, input int nslots, input string tag);
        logic is_left;
        is_left = fmt_i2s ? ~lv : lv;
        for (int k = 0; k < nslots; k++) begin
            logic  lj;
            string lt;
            exp_t  e;
            if (k == 0 && is_left && in_valid) begin
                m_left = in_left; m_right = in_right;
                exp_acc++; drop_valid = 1'b1;
            end
            if (k < SW) begin
                lj = is_left ? m_left[SW-1-k] : m_right[SW-1-k];
                lt = tag;
            end else begin
                lj = 1'b0;
                lt = "R5";
            end
            if (fmt_i2s) begin e.b = m_prev; e.tag = m_prev_tag; end
            else         begin e.b = lj;     e.tag = lt;         end
            q.push_back(e);
            m_prev = lj; m_prev_tag = lt;
            slot_step(lv);
        end
    endtask

    task automatic offer(input logic [SW-1:0] l, input logic [SW-1:0] r);
        in_left = l; in_right = r; in_valid = 1'b1;
    endtask

    task automatic drain();
        repeat (16) @(negedge clk);
        check_int("R2", q.size(), 0);
    endtask

    initial begin
        // justified format, 64-clock frames
        do_reset(1'b0);
        offer(24'h800001, 24'h7FFFFE);
        run_half(1'b1, 32, "R3");
        run_half(1'b0, 32, "R3");
        check_int("R7", acc_cnt, exp_acc);
        offer(24'hA5C3F0, 24'h0F3C5A);
        run_half(1'b1, 32, "R2");
        run_half(1'b0, 32, "R2");
        // no new pair: previous one repeats
        run_half(1'b1, 32, "R8");
        run_half(1'b0, 32, "R8");
        check_int("R8", acc_cnt, exp_acc);
        // switch to 48-clock frames without any setting
        offer(24'h123456, 24'hFEDCBA);
        run_half(1'b1, 24, "R9");
        run_half(1'b0, 24, "R9");
        run_half(1'b1, 24, "R9");
        drain();
        check_int("R7", acc_cnt, exp_acc);

        // delayed format, 64-clock frames
        do_reset(1'b1);
        offer(24'hC00003, 24'h3FFFFC);
        run_half(1'b1, 32, "R4");
        run_half(1'b0, 32, "R4");
        run_half(1'b1, 32, "R4");
        check_int("R7", acc_cnt, exp_acc);
        run_half(1'b0, 32, "R8");
        run_half(1'b1, 32, "R8");
        check_int("R8", acc_cnt, exp_acc);
        // 48-clock frames: last bit lands in the next half
        offer(24'h5A5A5B, 24'hB4B4B5);
        run_half(1'b0, 24, "R9");
        run_half(1'b1, 24, "R9");
        offer(24'h000001, 24'hFFFFFF);
        run_half(1'b0, 24, "R4");
        run_half(1'b1, 24, "R4");
        run_half(1'b0, 24, "R8");
        drain();
        check_int("R7", acc_cnt, exp_acc);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule